// File: doc/BRIEF.md
# Quad-Precision Round-to-Integral Unit

This unit takes one 128-bit binary floating-point operand and returns the same value rounded to an integral value. The result stays in the same 128-bit format. It serves a floating-point pipeline stage that carries out a "round to integer" operation on quad-precision data. One clock after the operand is presented, the registered result appears together with its status: an invalid flag, a signalling-NaN cause flag, an inexact flag and a 5-bit class code for the rounded value.

The rounding mode comes from two fields of the operation word. The first is a one-bit selector. The second is a two-bit mode code. With the selector clear, the two-bit code can also defer to a dynamic mode that a status register supplies on a separate input. A separate enable bit decides whether discarded fraction bits are reported as inexact. The unit contains no register-file access, no trapping and no other arithmetic.

Top module: `qp_round_int`

## Requirements
- R1: The operand is 1 sign bit [127], a 15-bit exponent [126:112] with bias 16383, and a 112-bit fraction [111:0]. Infinities, zeros, quiet NaNs (exponent all ones, fraction bit 111 set) and finite values with unbiased exponent of 112 or more pass through unchanged, with every flag clear.
- R2: With sel_r_i=1, sel_rmc_i selects the mode: 00 is nearest-even, 01 is toward zero, 10 is toward +infinity, and 11 is toward -infinity.
- R3: With sel_r_i=0 and sel_rmc_i=00, rounding is to nearest with ties away from zero. For example, 2.5 becomes 3 and -2.5 becomes -3.
- R4: With sel_r_i=0 and sel_rmc_i=11, the mode is taken from dyn_rm_i, which uses the same encoding as R2 (00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf).
- R5: With sel_r_i=0 and sel_rmc_i equal to 01 or 10, the unit rounds to nearest-even.
- R6: A nonzero finite input with magnitude below 1 becomes ±0 or ±1 (exponent 0 or 16383, fraction 0), chosen by the mode. The input's sign is kept. No output ever has a nonzero fraction with a zero exponent.
- R7: If rounding up carries out of the integer part, the exponent rises by one and the fraction becomes zero. For example, 1.99… rounded toward +inf gives 2.
- R8: A signalling NaN (exponent all ones, fraction nonzero, bit 111 clear) sets invalid_o and snan_cause_o. The result is the input with bit 111 set.
- R9: inexact_o is 1 only when ex_en_i=1 and rounding discarded nonzero fraction bits. When ex_en_i=0, inexact_o stays 0.
- R10: class_o describes res_o. The codes are: quiet NaN 10001, -inf 01001, -normal 01000, -denormal 11000, -zero 10010, +zero 00010, +denormal 10100, +normal 00100, +inf 00101.
- R11: All outputs are registered. They reflect the inputs one rising clock edge later. While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 128 | Operand |
| sel_r_i | input | 1 | Rounding selector bit |
| sel_rmc_i | input | 2 | Rounding mode code |
| dyn_rm_i | input | 2 | Dynamic rounding mode from the status register |
| ex_en_i | input | 1 | Inexact reporting enable |
| res_o | output | 128 | Rounded result |
| invalid_o | output | 1 | Invalid operation flag |
| snan_cause_o | output | 1 | Invalid caused by a signalling NaN |
| inexact_o | output | 1 | Inexact flag (gated by ex_en_i) |
| class_o | output | 5 | Class code of res_o |

## Verification
Two effects can occur in the same cycle: a rounding increment that carries into the exponent, and the raising of inexact under control of the enable bit. The carry also changes the class code that is computed from the rounded result. These are provoked with an all-ones fraction rounded toward +infinity and toward -infinity, with the enable bit first set and then cleared. Sub-one magnitudes are provoked in every mode. In each case the bench's behavioural model predicts the exponent, the fraction, the flag and the class code, and compares all of them in the single cycle where the registered output changes. Random operands spread over the exponents near the integral boundary then cross the mode decoding with the gated inexact flag.

// File: rtl/qpr_pkg.sv
package qpr_pkg;
  // Internal rounding modes; low two bits match the external 2-bit encoding.
  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_ZERO      = 3'd1,
    RM_POS       = 3'd2,
    RM_NEG       = 3'd3,
    RM_NEAR_AWAY = 3'd4
  } rmode_e;

  localparam int unsigned CLS_W = 5;
  localparam logic [CLS_W-1:0] CLS_QNAN  = 5'b10001;
  localparam logic [CLS_W-1:0] CLS_NINF  = 5'b01001;
  localparam logic [CLS_W-1:0] CLS_NNORM = 5'b01000;
  localparam logic [CLS_W-1:0] CLS_NDEN  = 5'b11000;
  localparam logic [CLS_W-1:0] CLS_NZERO = 5'b10010;
  localparam logic [CLS_W-1:0] CLS_PZERO = 5'b00010;
  localparam logic [CLS_W-1:0] CLS_PDEN  = 5'b10100;
  localparam logic [CLS_W-1:0] CLS_PNORM = 5'b00100;
  localparam logic [CLS_W-1:0] CLS_PINF  = 5'b00101;
endpackage

// File: rtl/qpr_mode_decode.sv
module qpr_mode_decode
  import qpr_pkg::*;
(
  input  logic       sel_r_i,
  input  logic [1:0] sel_rmc_i,
  input  logic [1:0] dyn_rm_i,
  output rmode_e     mode_o
);
  always_comb begin
    if (sel_r_i) begin
      mode_o = rmode_e'({1'b0, sel_rmc_i});
    end else begin
      unique case (sel_rmc_i)
        2'b00:   mode_o = RM_NEAR_AWAY;
        2'b11:   mode_o = rmode_e'({1'b0, dyn_rm_i});
        default: mode_o = RM_NEAR_EVEN;   // reserved codes
      endcase
    end
  end
endmodule

// File: rtl/qpr_round_core.sv
module qpr_round_core
  import qpr_pkg::*;
#(
  parameter int unsigned EXP_W  = 15,
  parameter int unsigned FRAC_W = 112
) (
  input  logic [EXP_W+FRAC_W:0] op_i,
  input  rmode_e                mode_i,
  output logic [EXP_W+FRAC_W:0] res_o,
  output logic                  inexact_o,
  output logic                  snan_o
);
  localparam int unsigned SIG_W     = FRAC_W + 1;
  localparam int unsigned BIAS_I    = (2 ** (EXP_W - 1)) - 1;
  localparam int unsigned BIG_I     = BIAS_I + FRAC_W;
  localparam logic [EXP_W-1:0] BIAS     = BIAS_I[EXP_W-1:0];
  localparam logic [EXP_W-1:0] BIG_EXP  = BIG_I[EXP_W-1:0];
  localparam logic [EXP_W-1:0] HALF_EXP = BIAS - 1'b1;
  localparam logic [EXP_W-1:0] EXP_ONES = '1;

  logic              sign_f;
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign sign_f = op_i[EXP_W+FRAC_W];
  assign exp_f  = op_i[EXP_W+FRAC_W-1:FRAC_W];
  assign frac_f = op_i[FRAC_W-1:0];

  // operand categories
  logic is_special, is_nan, is_zero, is_big, is_tiny;
  assign is_special = (exp_f == EXP_ONES);
  assign is_nan     = is_special && (frac_f != '0);
  assign is_zero    = (exp_f == '0) && (frac_f == '0);
  assign is_big     = !is_special && (exp_f >= BIG_EXP);
  assign is_tiny    = !is_zero && (exp_f < BIAS);

  // integral boundary for the in-range path
  logic [EXP_W-1:0] sh_amt;
  logic [SIG_W-1:0] sig, frac_mask, unit, half, rem, trunc;
  logic [SIG_W:0]   sum;
  logic             lsb, rem_nz, rem_gt, rem_eq, up_mid, carry;

  assign sh_amt    = exp_f - BIAS + 1'b1;
  assign sig       = {1'b1, frac_f};
  assign frac_mask = {SIG_W{1'b1}} >> sh_amt;
  assign unit      = frac_mask + 1'b1;
  assign half      = unit >> 1;
  assign rem       = sig & frac_mask;
  assign trunc     = sig & ~frac_mask;
  assign lsb       = |(sig & unit);
  assign rem_nz    = (rem != '0);
  assign rem_gt    = (rem > half);
  assign rem_eq    = (rem == half);

  always_comb begin
    unique case (mode_i)
      RM_NEAR_EVEN: up_mid = rem_gt || (rem_eq && lsb);
      RM_NEAR_AWAY: up_mid = rem_gt || rem_eq;
      RM_POS:       up_mid = rem_nz && !sign_f;
      RM_NEG:       up_mid = rem_nz && sign_f;
      default:      up_mid = 1'b0;
    endcase
  end

  assign sum   = {1'b0, trunc} + (up_mid ? {1'b0, unit} : '0);
  assign carry = sum[SIG_W];

  // magnitude below one: result is zero or one
  logic to_one;
  always_comb begin
    unique case (mode_i)
      RM_NEAR_EVEN: to_one = (exp_f == HALF_EXP) && (frac_f != '0);
      RM_NEAR_AWAY: to_one = (exp_f == HALF_EXP);
      RM_POS:       to_one = !sign_f;
      RM_NEG:       to_one = sign_f;
      default:      to_one = 1'b0;
    endcase
  end

  always_comb begin
    res_o     = op_i;
    inexact_o = 1'b0;
    snan_o    = 1'b0;
    if (is_nan) begin
      snan_o             = !frac_f[FRAC_W-1];
      res_o[FRAC_W-1]    = 1'b1;
    end else if (is_special || is_zero || is_big) begin
      res_o = op_i;
    end else if (is_tiny) begin
      inexact_o = 1'b1;
      res_o     = {sign_f, (to_one ? BIAS : {EXP_W{1'b0}}), {FRAC_W{1'b0}}};
    end else begin
      inexact_o = rem_nz;
      res_o     = {sign_f,
                   (carry ? exp_f + 1'b1 : exp_f),
                   (carry ? {FRAC_W{1'b0}} : sum[FRAC_W-1:0])};
    end
  end
endmodule

// File: rtl/qpr_classify.sv
module qpr_classify
  import qpr_pkg::*;
#(
  parameter int unsigned EXP_W  = 15,
  parameter int unsigned FRAC_W = 112
) (
  input  logic [EXP_W+FRAC_W:0] val_i,
  output logic [CLS_W-1:0]      class_o
);
  logic              s;
  logic [EXP_W-1:0]  e;
  logic [FRAC_W-1:0] f;
  assign s = val_i[EXP_W+FRAC_W];
  assign e = val_i[EXP_W+FRAC_W-1:FRAC_W];
  assign f = val_i[FRAC_W-1:0];

  always_comb begin
    if (e == '1) begin
      if (f != '0) class_o = CLS_QNAN;
      else         class_o = s ? CLS_NINF : CLS_PINF;
    end else if (e == '0) begin
      if (f == '0) class_o = s ? CLS_NZERO : CLS_PZERO;
      else         class_o = s ? CLS_NDEN : CLS_PDEN;
    end else begin
      class_o = s ? CLS_NNORM : CLS_PNORM;
    end
  end
endmodule

// File: rtl/qp_round_int.sv
module qp_round_int
  import qpr_pkg::*;
#(
  parameter int unsigned EXP_W  = 15,
  parameter int unsigned FRAC_W = 112
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [EXP_W+FRAC_W:0] op_i,
  input  logic                  sel_r_i,
  input  logic [1:0]            sel_rmc_i,
  input  logic [1:0]            dyn_rm_i,
  input  logic                  ex_en_i,
  output logic [EXP_W+FRAC_W:0] res_o,
  output logic                  invalid_o,
  output logic                  snan_cause_o,
  output logic                  inexact_o,
  output logic [4:0]            class_o
);
  localparam int unsigned W       = EXP_W + FRAC_W + 1;
  localparam int unsigned BIAS_I  = (2 ** (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] BIAS = BIAS_I[EXP_W-1:0];

  rmode_e           mode;
  logic [W-1:0]     res_nxt;
  logic             inx_raw, snan_nxt;
  logic [CLS_W-1:0] cls_nxt;
  logic             upd_en;

  qpr_mode_decode u_dec (
    .sel_r_i   (sel_r_i),
    .sel_rmc_i (sel_rmc_i),
    .dyn_rm_i  (dyn_rm_i),
    .mode_o    (mode)
  );

  qpr_round_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_core (
    .op_i      (op_i),
    .mode_i    (mode),
    .res_o     (res_nxt),
    .inexact_o (inx_raw),
    .snan_o    (snan_nxt)
  );

  qpr_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
    .val_i   (res_nxt),
    .class_o (cls_nxt)
  );

  assign upd_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o        <= '0;
      invalid_o    <= 1'b0;
      snan_cause_o <= 1'b0;
      inexact_o    <= 1'b0;
      class_o      <= '0;
    end else if (upd_en) begin
      res_o        <= res_nxt;
      invalid_o    <= snan_nxt;
      snan_cause_o <= snan_nxt;
      inexact_o    <= inx_raw && ex_en_i;
      class_o      <= cls_nxt;
    end
  end

  // R9
  inexact_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inexact_o |-> $past(ex_en_i));

  // R8
  snan_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snan_cause_o |-> invalid_o);

  // R8
  snan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |-> (res_o[W-2:FRAC_W] == '1) && res_o[FRAC_W-1]);

  // R6
  integral_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_o[W-2:FRAC_W] != '1 && res_o[W-2:FRAC_W] != '0) |-> res_o[W-2:FRAC_W] >= BIAS);

  // R6
  no_denorm_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_i[W-2:FRAC_W]) != '0 |-> !(res_o[W-2:FRAC_W] == '0 && res_o[FRAC_W-1:0] != '0));

  // R10
  nan_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_o[W-2:FRAC_W] == '1 && res_o[FRAC_W-1:0] != '0) |-> class_o == CLS_QNAN);
endmodule

// File: tb/test_qp_round_int.sv
module test_qp_round_int;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [127:0] op_i;
  logic         sel_r_i;
  logic [1:0]   sel_rmc_i, dyn_rm_i;
  logic         ex_en_i;
  logic [127:0] res_o;
  logic         invalid_o, snan_cause_o, inexact_o;
  logic [4:0]   class_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  qp_round_int i_qp_round_int (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .sel_r_i(sel_r_i),
    .sel_rmc_i(sel_rmc_i), .dyn_rm_i(dyn_rm_i), .ex_en_i(ex_en_i),
    .res_o(res_o), .invalid_o(invalid_o), .snan_cause_o(snan_cause_o),
    .inexact_o(inexact_o), .class_o(class_o)
  );

  // expected values for the vector currently in flight
  logic [127:0] e_res;
  logic         e_inv, e_inx;
  logic [4:0]   e_cls;
  bit           pend = 0;
  string        pend_tag;

  function automatic logic [127:0] mk(input bit s, input int e, input logic [15:0] top);
    logic [14:0] eb;
    eb = 15'(16383 + e);
    return {s, eb, top, 96'h0};
  endfunction

  function automatic logic [4:0] ref_class(input logic [127:0] v);
    if (v[126:112] == 15'h7fff) begin
      if (v[111:0] != 0) return 5'b10001;
      return v[127] ? 5'b01001 : 5'b00101;
    end
    if (v[126:112] == 0) begin
      if (v[111:0] == 0) return v[127] ? 5'b10010 : 5'b00010;
      return v[127] ? 5'b11000 : 5'b10100;
    end
    return v[127] ? 5'b01000 : 5'b00100;
  endfunction

  task automatic ref_round(input logic [127:0] a, input logic r, input logic [1:0] rmc,
                           input logic [1:0] dyn, input logic ex,
                           output logic [127:0] res, output logic inv, output logic inx);
    int m, e, nd;
    bit s, up, one, lost;
    logic [113:0] sig, ip, rm, hf;
    if (r) m = rmc;
    else if (rmc == 2'b00) m = 4;
    else if (rmc == 2'b11) m = dyn;
    else m = 0;
    s = a[127]; inv = 0; lost = 0; res = a;
    if (a[126:112] == 15'h7fff) begin
      if (a[111:0] != 0 && !a[111]) inv = 1;
      if (a[111:0] != 0) res[111] = 1'b1;
    end else if (a[126:112] == 0 && a[111:0] == 0) begin
      res = a;
    end else begin
      e = int'(a[126:112]) - 16383;
      if (e >= 112) res = a;
      else if (e < 0) begin
        lost = 1;
        case (m)
          4: one = (e == -1);
          0: one = (e == -1) && (a[111:0] != 0);
          1: one = 0;
          2: one = !s;
          default: one = s;
        endcase
        res = {s, (one ? 15'h3fff : 15'h0), 112'h0};
      end else begin
        nd  = 112 - e;
        sig = {2'b01, a[111:0]};
        ip  = sig >> nd;
        rm  = sig - (ip << nd);
        hf  = 114'd1 << (nd - 1);
        lost = (rm != 0);
        case (m)
          0: up = (rm > hf) || (rm == hf && ip[0]);
          4: up = (rm >= hf);
          1: up = 0;
          2: up = lost && !s;
          default: up = lost && s;
        endcase
        ip = ip + 114'(up);
        if (ip == (114'd1 << (e + 1)))
          res = {s, a[126:112] + 15'd1, 112'h0};
        else begin
          sig = ip << nd;
          res = {s, a[126:112], sig[111:0]};
        end
      end
    end
    inx = lost && ex;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (res_o !== e_res) begin
      errors++; $display("FAIL %s result act=%h exp=%h", tag, res_o, e_res);
    end
    checks++;
    if (invalid_o !== e_inv || snan_cause_o !== e_inv) begin
      errors++; $display("FAIL %s invalid/cause act=%b/%b exp=%b", tag, invalid_o, snan_cause_o, e_inv);
    end
    checks++;
    if (inexact_o !== e_inx) begin
      errors++; $display("FAIL %s inexact act=%b exp=%b", tag, inexact_o, e_inx);
    end
    checks++;
    if (class_o !== e_cls) begin
      errors++; $display("FAIL R10 (%s) class act=%b exp=%b", tag, class_o, e_cls);
    end
  endtask

  task automatic step(input logic [127:0] a, input logic r, input logic [1:0] rmc,
                      input logic [1:0] dyn, input logic ex, input string tag);
    @(negedge clk);
    if (pend) compare(pend_tag);
    op_i = a; sel_r_i = r; sel_rmc_i = rmc; dyn_rm_i = dyn; ex_en_i = ex;
    ref_round(a, r, rmc, dyn, ex, e_res, e_inv, e_inx);
    e_cls = ref_class(e_res);
    pend = 1; pend_tag = tag;
  endtask

  task automatic flush();
    @(negedge clk);
    if (pend) compare(pend_tag);
    pend = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; op_i = '0; sel_r_i = 0; sel_rmc_i = 0; dyn_rm_i = 0; ex_en_i = 0;
    repeat (3) @(negedge clk);
    op_i = mk(0, 1, 16'h4000); ex_en_i = 1;
    @(negedge clk);
    // R11: outputs held at zero in reset
    checks++;
    if (res_o !== 0 || invalid_o || snan_cause_o || inexact_o || class_o !== 0) begin
      errors++; $display("FAIL R11 reset act=%h exp=0", res_o);
    end
    rst_n = 1;

    // R3 ties away
    step(mk(0, 1, 16'h4000), 0, 2'b00, 2'b01, 1, "R3 +2.5 away");
    step(mk(1, 1, 16'h4000), 0, 2'b00, 2'b01, 1, "R3 -2.5 away");
    // R2 modes
    step(mk(0, 1, 16'h4000), 1, 2'b00, 2'b11, 1, "R2 2.5 even");
    step(mk(0, 1, 16'hC000), 1, 2'b00, 2'b11, 1, "R2 3.5 even");
    step(mk(1, 1, 16'hC000), 1, 2'b01, 2'b00, 1, "R2 -3.5 zero");
    step(mk(1, 1, 16'h4000), 1, 2'b10, 2'b00, 1, "R2 -2.5 +inf");
    step(mk(1, 1, 16'h4000), 1, 2'b11, 2'b00, 1, "R2 -2.5 -inf");
    // R4 dynamic
    for (int d = 0; d < 4; d++)
      step(mk(1, 2, 16'h5000), 0, 2'b11, 2'(d), 1, "R4 dynamic");
    // R5 reserved
    step(mk(0, 1, 16'h4000), 0, 2'b01, 2'b10, 1, "R5 reserved 01");
    step(mk(0, 3, 16'h9000), 0, 2'b10, 2'b10, 1, "R5 reserved 10");
    // R6 sub-one
    for (int mm = 0; mm < 4; mm++) begin
      step(mk(0, -2, 16'h3333), 1, 2'(mm), 2'b00, 1, "R6 +0.3");
      step(mk(1, -1, 16'h6666), 1, 2'(mm), 2'b00, 1, "R6 -0.7");
      step(mk(0, -1, 16'h0000), 1, 2'(mm), 2'b00, 1, "R6 0.5");
    end
    step(mk(0, -1, 16'h0000), 0, 2'b00, 2'b00, 1, "R6 0.5 away");
    step({1'b1, 15'h0, 112'h5}, 1, 2'b11, 2'b00, 1, "R6 denormal -inf");
    // R7 carry, with and without inexact (R9)
    step({1'b0, 15'h3fff, {112{1'b1}}}, 1, 2'b10, 2'b00, 1, "R7 carry +inf");
    step({1'b1, 15'h3fff, {112{1'b1}}}, 1, 2'b11, 2'b00, 0, "R7 carry -inf R9 ex0");
    step({1'b0, 15'h406e, {112{1'b1}}}, 1, 2'b10, 2'b00, 1, "R7 carry top e111");
    // R9 suppression
    step(mk(0, 4, 16'h1234), 1, 2'b01, 2'b00, 0, "R9 ex0");
    step(mk(0, 4, 16'h1000), 1, 2'b01, 2'b00, 1, "R9 exact");
    // R1 pass-through
    step({1'b0, 15'h406f, 112'h1234}, 1, 2'b10, 2'b00, 1, "R1 big");
    step({1'b1, 15'h7fff, 112'h0}, 1, 2'b10, 2'b00, 1, "R1 -inf");
    step({1'b1, 15'h0, 112'h0}, 1, 2'b10, 2'b00, 1, "R1 -zero");
    step({1'b0, 15'h7fff, 1'b1, 111'h77}, 1, 2'b00, 2'b00, 1, "R1 qnan");
    // R8 snan
    step({1'b1, 15'h7fff, 1'b0, 111'h9}, 1, 2'b00, 2'b00, 1, "R8 snan");
    step({1'b0, 15'h7fff, 1'b0, 111'h1}, 0, 2'b00, 2'b00, 0, "R8 snan ex0");
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [127:0] a;
      int e;
      e = int'($urandom_range(0, 125)) - 5;
      a = {$urandom, $urandom, $urandom, $urandom};
      a[126:112] = 15'(16383 + e);
      if (k % 37 == 0) a[126:112] = 15'h7fff;
      step(a, 1'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), "R2 R9 random");
    end
    flush();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule